// File: doc/BRIEF.md
# Configurable DSP Functional Unit

This block is one arithmetic lane of a four-lane DSP datapath. It does not decode wide instructions itself. Each cycle it receives a compact command: an enable bit, a writeback bit and a 5-bit slot number. The slot number selects one of 32 micro-instructions held in a small local configuration store. The selected micro-instruction decides which arithmetic operation runs on the two 16-bit operand words. It also names the destination accumulator, the source accumulator, a shift amount and an optional data move. The unit holds four 40-bit accumulators.

A data move can copy an accumulator to another local accumulator, send it to the neighbouring lane, or emit it to the output RAM as a saturated 16-bit word. A data move runs in the same cycle as the arithmetic operation and reads the accumulator values from before that cycle. The configuration store can be rewritten between any two commands, so the lane can be retargeted while it runs. Another lane can also write one of this lane's accumulators through the neighbour input.

Top module: `dsp_fu`

## Requirements
- R1: After reset, all four accumulators read zero, `out_we` and `nb_out_valid` are low, and every configuration slot holds the all-zero word, which means no operation and no move.
- R2: The micro-instruction word is 19 bits, packed from the most significant bit down as follows: op[18:16], dst[15:14], src[13:12], signed shift[11:6], move kind[5:4], move source[3:2], move destination[1:0]. A configuration write on one edge is used by a command issued on a later edge. Each command with `ins_en` high executes the word in slot `ins_addr` and updates the accumulators on that edge.
- R3: The op codes are 0 no-op, 1 add, 2 subtract, 3 multiply, 4 multiply-accumulate, 5 shift, 6 normalize, 7 distance. Add, subtract and distance (the absolute difference) form a 17-bit signed result from the signed operands and sign-extend it to 40 bits into acc[dst].
- R4: With `ins_en` low, the unit's own command changes no accumulator and raises neither output strobe.
- R5: With `ins_wb` low, the result is not written, and any data move in the same micro-instruction still takes place.
- R6: Multiply writes the sign-extended 32-bit signed product to acc[dst]. Multiply-accumulate adds that product to acc[dst], wrapping modulo 2^40.
- R7: Normalize writes to acc[dst] the count of bits below bit 39 of acc[src] that equal bit 39. The count is 39 for 0 and for -1, and it is always below 40.
- R8: Shift writes acc[src] shifted by the signed 6-bit amount into acc[dst]. A positive amount shifts left and a negative amount shifts arithmetically right, down to -32.
- R9: The move kinds are 0 none, 1 local copy acc[msrc] to acc[mdst], 2 neighbour send, and 3 output. A neighbour send raises `nb_out_valid` with acc[msrc] and the index mdst on the next edge. A high `nb_in_valid` writes `nb_in_data` into acc[`nb_in_sel`] whatever the value of `ins_en`.
- R10: When several writes target one accumulator on the same edge, the result wins over the local copy, and the local copy wins over the neighbour input.
- R11: An output move raises `out_we` for one cycle on the next edge. `out_data` carries bits [31:16] of acc[msrc] when the value fits in 32 signed bits. Otherwise it carries 0x7FFF for positive values and 0x8000 for negative ones.
- R12: Data moves and the neighbour send use the accumulator values from before the edge, even when the operation in the same command rewrites the source accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Command enable |
| ins_wb | input | 1 | Result writeback enable |
| ins_addr | input | 5 | Configuration slot to execute |
| opnd_a | input | 16 | First operand word, signed |
| opnd_b | input | 16 | Second operand word, signed |
| cfg_we | input | 1 | Configuration slot write strobe |
| cfg_addr | input | 5 | Configuration slot written |
| cfg_wdata | input | 19 | Micro-instruction word written |
| nb_in_valid | input | 1 | Neighbour write strobe |
| nb_in_sel | input | 2 | Accumulator written by the neighbour |
| nb_in_data | input | 40 | Neighbour write value |
| nb_out_valid | output | 1 | Send to the neighbour lane |
| nb_out_sel | output | 2 | Accumulator index in the neighbour |
| nb_out_data | output | 40 | Value sent to the neighbour |
| out_we | output | 1 | Output RAM write strobe |
| out_data | output | 16 | Saturated upper word written to the output RAM |

## Verification
The accumulators are visible only through moves. A wrong accumulator therefore shows up in the `nb_out_data` of a later neighbour send, or in a wrong saturated word on `out_data`. Either appears one edge after the command that reads the bad value. An early neighbour send catches a bad operand or configuration slot at once. A write-priority fault only shows when the affected accumulator is sent out afterwards, so each command in the stimulus is followed by a send of all four accumulators. A strobe error (a send or output write while the lane is disabled) appears on the cycle right after the faulty command.

// File: rtl/dsp_fu_pkg.sv
package dsp_fu_pkg;
  parameter int DW        = 16;
  parameter int AW        = 40;
  parameter int NACC      = 4;
  parameter int SELW      = $clog2(NACC);
  parameter int CFG_DEPTH = 32;
  parameter int CAW       = $clog2(CFG_DEPTH);
  parameter int SHW       = 6;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_MPY = 3'd3,
    OP_MAC = 3'd4, OP_SHF = 3'd5, OP_NRM = 3'd6, OP_DST = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0, MV_INT = 2'd1, MV_NBR = 2'd2, MV_OUT = 2'd3
  } mv_e;

  typedef struct packed {
    op_e                   op;
    logic [SELW-1:0]       dst;
    logic [SELW-1:0]       src;
    logic signed [SHW-1:0] sh;
    mv_e                   mv;
    logic [SELW-1:0]       msrc;
    logic [SELW-1:0]       mdst;
  } uinstr_t;

  localparam int UW = $bits(uinstr_t);

  // sign-extend a DW+1 bit value to accumulator width
  function automatic logic [AW-1:0] sext_wide(input logic [DW:0] v);
    return {{(AW-DW-1){v[DW]}}, v};
  endfunction

  // sign-extend a product to accumulator width
  function automatic logic [AW-1:0] sext_prod(input logic [2*DW-1:0] v);
    return {{(AW-2*DW){v[2*DW-1]}}, v};
  endfunction

  // upper word of the low 2*DW bits, clamped when the value exceeds 2*DW signed bits
  function automatic logic [DW-1:0] out_sat(input logic [AW-1:0] v);
    logic [AW-2*DW:0] hi;
    logic             fits;
    hi   = v[AW-1:2*DW-1];
    fits = (&hi) | ~(|hi);
    if (fits) return v[2*DW-1:DW];
    else if (v[AW-1]) return {1'b1, {(DW-1){1'b0}}};
    else return {1'b0, {(DW-1){1'b1}}};
  endfunction

  // redundant sign bits: leading zeros of (v xor sign) below the MSB
  function automatic logic [AW-1:0] nrm_count(input logic [AW-1:0] v);
    logic [AW-2:0] d;
    logic          done;
    logic [AW-1:0] n;
    d    = v[AW-2:0] ^ {(AW-1){v[AW-1]}};
    done = 1'b0;
    n    = '0;
    for (int i = AW-2; i >= 0; i--) begin
      if (!done) begin
        if (d[i]) done = 1'b1;
        else n = n + 1'b1;
      end
    end
    return n;
  endfunction

  // signed shift: positive left, negative arithmetic right
  function automatic logic [AW-1:0] shift_acc(input logic [AW-1:0] v,
                                              input logic [SHW-1:0] sh);
    logic [SHW-1:0]       mag;
    logic signed [AW-1:0] s;
    s   = v;
    mag = sh[SHW-1] ? (~sh + 1'b1) : sh;
    if (sh[SHW-1]) return s >>> mag;
    else return v << mag;
  endfunction

  function automatic logic [AW-1:0] pick_acc(input logic [NACC*AW-1:0] flat,
                                             input logic [SELW-1:0] sel);
    return flat[sel*AW +: AW];
  endfunction
endpackage

// File: rtl/dsp_fu_cfgmem.sv
module dsp_fu_cfgmem #(
  parameter int DEPTH = 32,
  parameter int W     = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dsp_fu_alu.sv
module dsp_fu_alu
  import dsp_fu_pkg::*;
(
  input  op_e                   op,
  input  logic [DW-1:0]         a,
  input  logic [DW-1:0]         b,
  input  logic [AW-1:0]         acc_d,
  input  logic [AW-1:0]         acc_s,
  input  logic [SHW-1:0]        sh,
  output logic [AW-1:0]         res
);
  logic signed [DW:0]     sum, dif, mag;
  logic signed [2*DW-1:0] prod;

  always_comb begin
    sum  = {a[DW-1], a} + {b[DW-1], b};
    dif  = {a[DW-1], a} - {b[DW-1], b};
    mag  = dif[DW] ? -dif : dif;
    prod = $signed(a) * $signed(b);
    unique case (op)
      OP_ADD:  res = sext_wide(sum);
      OP_SUB:  res = sext_wide(dif);
      OP_DST:  res = sext_wide(mag);
      OP_MPY:  res = sext_prod(prod);
      OP_MAC:  res = acc_d + sext_prod(prod);
      OP_SHF:  res = shift_acc(acc_s, sh);
      OP_NRM:  res = nrm_count(acc_s);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/dsp_fu_accbank.sv
module dsp_fu_accbank
  import dsp_fu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_we,
  input  logic [SELW-1:0]      cmp_sel,
  input  logic [AW-1:0]        cmp_data,
  input  logic                 mv_we,
  input  logic [SELW-1:0]      mv_sel,
  input  logic [AW-1:0]        mv_data,
  input  logic                 nb_we,
  input  logic [SELW-1:0]      nb_sel,
  input  logic [AW-1:0]        nb_data,
  output logic [NACC*AW-1:0]   acc_flat
);
  for (genvar k = 0; k < NACC; k++) begin : g_acc
    logic [AW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (cmp_we && cmp_sel == SELW'(k)) q <= cmp_data;
      else if (mv_we && mv_sel == SELW'(k))   q <= mv_data;
      else if (nb_we && nb_sel == SELW'(k))   q <= nb_data;
    end
    assign acc_flat[k*AW +: AW] = q;
  end
endmodule

// File: rtl/dsp_fu.sv
module dsp_fu
  import dsp_fu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_en,
  input  logic            ins_wb,
  input  logic [CAW-1:0]  ins_addr,
  input  logic [DW-1:0]   opnd_a,
  input  logic [DW-1:0]   opnd_b,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [UW-1:0]   cfg_wdata,
  input  logic            nb_in_valid,
  input  logic [SELW-1:0] nb_in_sel,
  input  logic [AW-1:0]   nb_in_data,
  output logic            nb_out_valid,
  output logic [SELW-1:0] nb_out_sel,
  output logic [AW-1:0]   nb_out_data,
  output logic            out_we,
  output logic [DW-1:0]   out_data
);
  logic [UW-1:0]      cfg_rdata;
  uinstr_t            ui;
  logic [NACC*AW-1:0] acc_flat;
  logic [AW-1:0]      acc_dst, acc_src, acc_mv;
  logic [AW-1:0]      cmp_data;
  logic               cmp_we, mv_int_we, op_is_nrm;
  logic [SELW-1:0]    cmp_sel, mv_sel;

  dsp_fu_cfgmem #(.DEPTH(CFG_DEPTH), .W(UW)) i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .raddr(ins_addr), .rdata(cfg_rdata)
  );

  assign ui      = uinstr_t'(cfg_rdata);
  assign acc_dst = pick_acc(acc_flat, ui.dst);
  assign acc_src = pick_acc(acc_flat, ui.src);
  assign acc_mv  = pick_acc(acc_flat, ui.msrc);

  dsp_fu_alu i_alu (
    .op(ui.op), .a(opnd_a), .b(opnd_b), .acc_d(acc_dst),
    .acc_s(acc_src), .sh(ui.sh), .res(cmp_data)
  );

  // named internal events
  assign cmp_we    = ins_en & ins_wb & (ui.op != OP_NOP);
  assign cmp_sel   = ui.dst;
  assign mv_int_we = ins_en & (ui.mv == MV_INT);
  assign mv_sel    = ui.mdst;
  assign op_is_nrm = ins_en & (ui.op == OP_NRM);

  dsp_fu_accbank i_acc (
    .clk(clk), .rst_n(rst_n),
    .cmp_we(cmp_we), .cmp_sel(cmp_sel), .cmp_data(cmp_data),
    .mv_we(mv_int_we), .mv_sel(mv_sel), .mv_data(acc_mv),
    .nb_we(nb_in_valid), .nb_sel(nb_in_sel), .nb_data(nb_in_data),
    .acc_flat(acc_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_out_valid <= 1'b0;
      nb_out_sel   <= '0;
      nb_out_data  <= '0;
      out_we       <= 1'b0;
      out_data     <= '0;
    end else begin
      nb_out_valid <= ins_en & (ui.mv == MV_NBR);
      nb_out_sel   <= ui.mdst;
      nb_out_data  <= acc_mv;
      out_we       <= ins_en & (ui.mv == MV_OUT);
      out_data     <= out_sat(acc_mv);
    end
  end
endmodule

// File: rtl/dsp_fu_chk.sv
module dsp_fu_chk
  import dsp_fu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               ins_en,
  input logic               ins_wb,
  input logic               nb_in_valid,
  input logic               out_we,
  input logic               nb_out_valid,
  input logic [NACC*AW-1:0] acc_flat,
  input logic               cmp_we,
  input logic [SELW-1:0]    cmp_sel,
  input logic [AW-1:0]      cmp_data,
  input logic               mv_int_we,
  input logic [SELW-1:0]    mv_sel,
  input logic               op_is_nrm
);
  // R4: a disabled lane with no neighbour write keeps its accumulators
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_en && !nb_in_valid) |=> $stable(acc_flat));

  // R4: a disabled lane raises no strobe
  a_r4_idle_no_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_en |=> (!out_we && !nb_out_valid));

  // R5: writeback off with no move and no neighbour write leaves state alone
  a_r5_wb_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !ins_wb && !mv_int_we && !nb_in_valid) |=> $stable(acc_flat));

  // R10: the result beats a local copy to the same accumulator
  a_r10_compute_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && mv_int_we && cmp_sel == mv_sel) |=>
      (pick_acc(acc_flat, $past(cmp_sel)) == $past(cmp_data)));

  // R7: the sign-bit count never reaches the accumulator width
  always_comb begin
    if (rst_n && op_is_nrm) begin
      a_r7_norm_range: assert (cmp_data < AW);
    end
  end
endmodule

bind dsp_fu dsp_fu_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_wb(ins_wb),
  .nb_in_valid(nb_in_valid), .out_we(out_we), .nb_out_valid(nb_out_valid),
  .acc_flat(acc_flat), .cmp_we(cmp_we), .cmp_sel(cmp_sel),
  .cmp_data(cmp_data), .mv_int_we(mv_int_we), .mv_sel(mv_sel),
  .op_is_nrm(op_is_nrm)
);

// File: tb/test_dsp_fu.sv
`timescale 1ns/1ps
module test_dsp_fu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_en = 1'b0, ins_wb = 1'b0;
  logic [4:0]  ins_addr = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [18:0] cfg_wdata = '0;
  logic        nb_in_valid = 1'b0;
  logic [1:0]  nb_in_sel = '0;
  logic [39:0] nb_in_data = '0;
  logic        nb_out_valid, out_we;
  logic [1:0]  nb_out_sel;
  logic [39:0] nb_out_data;
  logic [15:0] out_data;

  dsp_fu i_dsp_fu (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int f_op[32], f_dst[32], f_src[32], f_sh[32], f_mv[32], f_ms[32], f_md[32];
  logic [39:0] m[4];
  logic        e_nbv, e_outv;
  logic [39:0] e_nbd;
  logic [15:0] e_outd;

  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {5'd0,  16'h1234, 16'h0F0F},
    {5'd1,  16'h8000, 16'h7FFF},
    {5'd2,  16'hFFFF, 16'h8000},
    {5'd3,  16'h8000, 16'h8000},
    {5'd3,  16'h7FFF, 16'h7FFF},
    {5'd4,  16'h8000, 16'h7FFF},
    {5'd5,  16'h0000, 16'h0000},
    {5'd6,  16'h0000, 16'h0000},
    {5'd7,  16'h0000, 16'h0000},
    {5'd8,  16'h0000, 16'h0000},
    {5'd9,  16'h0001, 16'h0002},
    {5'd11, 16'h0005, 16'hFFFA}
  };

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(input int s, input int op, input int dst, input int src,
                      input int sh, input int mv, input int ms, input int md);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 5'(s);
    cfg_wdata = {3'(op), 2'(dst), 2'(src), 6'(sh), 2'(mv), 2'(ms), 2'(md)};
    f_op[s] = op; f_dst[s] = dst; f_src[s] = src; f_sh[s] = sh;
    f_mv[s] = mv; f_ms[s] = ms; f_md[s] = md;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] b_sat(input logic [39:0] v);
    longint x;
    x = longint'($signed(v));
    if (x > 64'sd2147483647) return 16'h7FFF;
    if (x < -64'sd2147483648) return 16'h8000;
    return v[31:16];
  endfunction

  function automatic logic [39:0] b_result(input int s, input logic [15:0] a,
                                           input logic [15:0] b, input logic [39:0] od,
                                           input logic [39:0] os);
    longint x, y, r;
    int     n;
    x = longint'($signed(a));
    y = longint'($signed(b));
    case (f_op[s])
      1: r = x + y;
      2: r = x - y;
      3: r = x * y;
      4: r = longint'($signed(od)) + x * y;
      5: if (f_sh[s] >= 0) r = longint'($signed(os)) <<< f_sh[s];
         else r = longint'($signed(os)) >>> (-f_sh[s]);
      6: begin
           n = 0;
           for (int i = 38; i >= 0; i--) begin
             if (os[i] != os[39]) break;
             n++;
           end
           r = longint'(n);
         end
      7: r = (x > y) ? x - y : y - x;
      default: r = 0;
    endcase
    return r[39:0];
  endfunction

  task automatic issue(input int s, input logic [15:0] a, input logic [15:0] b,
                       input bit en, input bit wb, input bit nbv = 1'b0,
                       input int nbs = 0, input logic [39:0] nbd = '0);
    logic [39:0] old[4];
    @(negedge clk);
    ins_en = en; ins_wb = wb; ins_addr = 5'(s); opnd_a = a; opnd_b = b;
    nb_in_valid = nbv; nb_in_sel = 2'(nbs); nb_in_data = nbd;
    old = m;
    e_nbv = 1'b0; e_outv = 1'b0; e_nbd = '0; e_outd = '0;
    if (nbv) m[nbs] = nbd;
    if (en) begin
      case (f_mv[s])
        1: m[f_md[s]] = old[f_ms[s]];
        2: begin e_nbv = 1'b1; e_nbd = old[f_ms[s]]; end
        3: begin e_outv = 1'b1; e_outd = b_sat(old[f_ms[s]]); end
        default: ;
      endcase
      if (wb && f_op[s] != 0) m[f_dst[s]] = b_result(s, a, b, old[f_dst[s]], old[f_src[s]]);
    end
    @(negedge clk);
    ins_en = 1'b0; nb_in_valid = 1'b0;
  endtask

  task automatic check_strobes(input string req);
    check({req, " nb_out_valid"}, 40'(nb_out_valid), 40'(e_nbv));
    check({req, " out_we"}, 40'(out_we), 40'(e_outv));
    if (e_nbv) check({req, " nb_out_data"}, nb_out_data, e_nbd);
    if (e_outv) check({req, " out_data"}, 40'(out_data), 40'(e_outd));
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 4; k++) begin
      issue(28 + k, 16'h0, 16'h0, 1'b1, 1'b1);
      check($sformatf("%s acc%0d", req, k), nb_out_data, m[k]);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m[k] = '0;
    for (int s = 0; s < 32; s++) begin
      f_op[s] = 0; f_dst[s] = 0; f_src[s] = 0; f_sh[s] = 0;
      f_mv[s] = 0; f_ms[s] = 0; f_md[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: strobes low after reset
    @(negedge clk);
    check("R1 out_we", 40'(out_we), 40'd0);
    check("R1 nb_out_valid", 40'(nb_out_valid), 40'd0);
    for (int k = 0; k < 4; k++) prog(28 + k, 0, 0, 0, 0, 2, k, k);
    // R1: unwritten slot does nothing; accumulators zero
    issue(20, 16'h7777, 16'h1111, 1'b1, 1'b1);
    check_strobes("R1 empty slot");
    read_all("R1 reset");

    prog(0, 1, 0, 0, 0, 0, 0, 0);
    prog(1, 2, 1, 0, 0, 0, 0, 0);
    prog(2, 3, 2, 0, 0, 0, 0, 0);
    prog(3, 4, 2, 0, 0, 0, 0, 0);
    prog(4, 7, 3, 0, 0, 0, 0, 0);
    prog(5, 5, 0, 2, 4, 0, 0, 0);
    prog(6, 5, 1, 2, -3, 0, 0, 0);
    prog(7, 6, 3, 0, 0, 0, 0, 0);
    prog(8, 0, 0, 0, 0, 1, 2, 1);
    prog(9, 1, 1, 0, 0, 1, 0, 1);
    prog(10, 0, 0, 0, 0, 3, 2, 0);
    prog(11, 1, 0, 0, 0, 2, 3, 3);

    // table walk: R2 R3 R6 R8 R7 R9 R10 R12
    for (int v = 0; v < NV; v++) begin
      issue(int'(VEC[v][36:32]), VEC[v][31:16], VEC[v][15:0], 1'b1, 1'b1);
      check_strobes($sformatf("R9 R12 vec%0d", v));
      read_all($sformatf("R2 R3 R6 R7 R8 R10 vec%0d", v));
    end

    // R11: output of an in-range value
    issue(10, 16'h0, 16'h0, 1'b1, 1'b1);
    check_strobes("R11 in range");
    // R11: negative overflow clamps to 0x8000
    prog(16, 3, 0, 0, 0, 0, 0, 0);
    prog(17, 5, 0, 0, 2, 0, 0, 0);
    prog(18, 0, 0, 0, 0, 3, 0, 0);
    issue(16, 16'h8000, 16'h7FFF, 1'b1, 1'b1);
    issue(17, 16'h0, 16'h0, 1'b1, 1'b1);
    issue(18, 16'h0, 16'h0, 1'b1, 1'b1);
    check("R11 neg clamp", 40'(out_data), 40'h8000);
    check("R11 strobe", 40'(out_we), 40'd1);
    @(negedge clk);
    check("R11 single pulse", 40'(out_we), 40'd0);
    // R11: positive overflow clamps to 0x7FFF
    prog(12, 5, 0, 1, 20, 0, 0, 0);
    issue(1, 16'h7FFF, 16'h8000, 1'b1, 1'b1);
    issue(12, 16'h0, 16'h0, 1'b1, 1'b1);
    issue(18, 16'h0, 16'h0, 1'b1, 1'b1);
    check("R11 pos clamp", 40'(out_data), 40'h7FFF);

    // R4: disabled command changes nothing and emits nothing
    issue(11, 16'h1234, 16'h4321, 1'b0, 1'b1);
    check_strobes("R4 disabled");
    read_all("R4 disabled");
    // R5: writeback off, local copy still happens
    issue(0, 16'h0100, 16'h0200, 1'b1, 1'b1);
    issue(9, 16'h3333, 16'h4444, 1'b1, 1'b0);
    read_all("R5 wb off");
    // R9: neighbour write while disabled
    issue(0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 2, 40'h12_3456_789A);
    read_all("R9 neighbour in");
    // R10: local copy beats neighbour write
    issue(8, 16'h0, 16'h0, 1'b1, 1'b1, 1'b1, 1, 40'hAB_CDEF_0123);
    read_all("R10 copy over neighbour");
    // R10: result beats neighbour write
    issue(0, 16'h0002, 16'h0003, 1'b1, 1'b1, 1'b1, 0, 40'h55_5555_5555);
    read_all("R10 result over neighbour");
    // R7: normalize zero and minus one
    prog(19, 2, 0, 0, 0, 0, 0, 0);
    issue(19, 16'h0042, 16'h0042, 1'b1, 1'b1);
    issue(7, 16'h0, 16'h0, 1'b1, 1'b1);
    read_all("R7 zero");
    issue(19, 16'h0000, 16'h0001, 1'b1, 1'b1);
    issue(7, 16'h0, 16'h0, 1'b1, 1'b1);
    read_all("R7 minus one");
    // R8: full right shift of a negative value
    prog(20, 5, 1, 1, -32, 0, 0, 0);
    issue(1, 16'h8000, 16'h7FFF, 1'b1, 1'b1);
    issue(20, 16'h0, 16'h0, 1'b1, 1'b1);
    read_all("R8 shift -32");
    // R2: rewrite a slot mid-run
    prog(0, 7, 0, 0, 0, 0, 0, 0);
    issue(0, 16'h0003, 16'h0010, 1'b1, 1'b1);
    read_all("R2 rewrite");

    summary();
    $finish;
  end
endmodule